// File: doc/BRIEF.md
# Serial EEPROM Read Engine (Two-Wire Slave)

This block is a two-wire bus slave that behaves like a small serial EEPROM. The storage is 512 bytes of on-chip registers. The block runs on a system clock and samples SCL and SDA through a synchronizer. It tracks START, repeated START and STOP conditions. It accepts a slave address byte and, for write-direction transfers, a word address followed by optional data bytes. Data bytes go directly into the array, so a host can preload the memory and position the address pointer.

Reads come in three forms:
- A current-address read returns the byte after the last one touched, without a new address being sent.
- A random read first sends a write-direction header and a word address, then a repeated START and a read header.
- A sequential read keeps streaming for as long as the master acknowledges each byte, and wraps at the top of the array.

One address pointer is shared by reads and writes.

The slave only pulls SDA low, through a drive-low enable. The pad outside the block completes the open-drain connection. Every change of that enable is made while SCL is low.

Top module: `eeprom_rd_slave`

## Requirements
- R1: After reset the SDA drive-low enable is 0, and the slave stays released until a START is seen.
- R2: The slave acknowledges an address byte only when all of these hold: bits 7:4 equal 1010, bits 3:2 equal `strap_i` (default build), and the byte is sent MSB first. Bit 1 is the upper word-address bit (page bit) and bit 0 is R/W, where 1 means read. Any other address byte gets no ACK. After a non-matching address the slave ignores all traffic, without ACKs or writes, until the next START.
- R3: In a write-direction transfer, the byte that follows the address is acknowledged and sets the pointer to {page bit, byte}, a 9-bit address.
- R4: Each further write-direction byte is acknowledged and stored at the pointer, and the pointer then advances by one.
- R5: A read header with no preceding word address returns the byte at the pointer, which holds the last accessed address plus one.
- R6: A random read works as follows: write header, word address, repeated START, read header. It returns the byte at the loaded address, and the dummy write stores nothing.
- R7: Read data leaves MSB first. The drive-low enable changes only while SCL is low.
- R8: Each master ACK after a read byte makes the slave send the next byte. The pointer wraps from 511 to 0.
- R9: A master NACK after a read byte ends the transfer. The slave releases SDA, and the pointer has advanced once for each byte sent.
- R10: A repeated START at any point restarts address decoding. A write header followed by a repeated START and a read header reads from the unchanged pointer.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock used for oversampling |
| rst_n | input | 1 | Synchronous active-low reset |
| scl_i | input | 1 | Bus clock line level |
| sda_i | input | 1 | Bus data line level (wired result) |
| strap_i | input | 2 | Chip-select strap bits compared against address bits 3:2 |
| sda_drive_low_o | output | 1 | 1 pulls SDA low, 0 releases it |

## Verification
The bench builds the block with its default parameters: a 9-bit address, so one page bit and two strap bits, and a device code of 1010. With these values, a single transfer near address 0x1FC crosses the 511-to-0 wrap for both writing and reading. Using the page bit as address bit 8 is therefore exercised on both halves of the array. The strap inputs are tied to a value that is not all zeros or all ones, so a header with flipped strap bits must be refused.

// File: rtl/eeprom_pkg.sv
// Shared types for the serial EEPROM slave.
package eeprom_pkg;

    // Bus-level phase of the slave controller.
    typedef enum logic [2:0] {
        S_IDLE,   // released, waiting for START
        S_RX,     // shifting in a byte from the master
        S_ACK,    // driving ACK for a received byte
        S_TX,     // shifting out a read byte
        S_RACK    // released, reading the master's ACK/NACK
    } state_t;

    // Meaning of the byte currently being received.
    typedef enum logic [1:0] {
        K_DEV,    // slave address byte
        K_WADDR,  // word address byte
        K_WDATA   // data byte to store
    } kind_t;

endpackage

// File: rtl/eeprom_line_sync.sv
// Synchronizes SCL/SDA into the system clock domain and flags bus events.
// Assumes the system clock oversamples SCL by a comfortable margin
// (several clocks per SCL half period). Idle level of both lines is high.
module eeprom_line_sync (
    input  logic clk,
    input  logic rst_n,
    input  logic scl_i,
    input  logic sda_i,
    output logic sda_s,
    output logic scl_rise,
    output logic scl_fall,
    output logic start_det,
    output logic stop_det
);
    logic [1:0] scl_pipe, sda_pipe;
    logic       scl_q, sda_q;

    // Two-flop synchronizer plus one history stage for edge detection.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            scl_pipe <= 2'b11;
            sda_pipe <= 2'b11;
            scl_q    <= 1'b1;
            sda_q    <= 1'b1;
        end else begin
            scl_pipe <= {scl_pipe[0], scl_i};
            sda_pipe <= {sda_pipe[0], sda_i};
            scl_q    <= scl_pipe[1];
            sda_q    <= sda_pipe[1];
        end
    end

    // Edge and condition decode on the synchronized lines.
    always_comb begin
        sda_s     = sda_pipe[1];
        scl_rise  = scl_pipe[1] & ~scl_q;
        scl_fall  = ~scl_pipe[1] & scl_q;
        start_det = scl_pipe[1] & scl_q & sda_q & ~sda_pipe[1];
        stop_det  = scl_pipe[1] & scl_q & ~sda_q & sda_pipe[1];
    end
endmodule

// File: rtl/eeprom_addr_ctr.sv
// Shared address pointer: holds the next address to access.
// Load has priority over increment; increment wraps at 2**ADDR_W.
module eeprom_addr_ctr #(
    parameter int ADDR_W = 9
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load,
    input  logic [ADDR_W-1:0] load_val,
    input  logic              inc,
    output logic [ADDR_W-1:0] ptr
);
    // Pointer register with load and wrapping increment.
    always_ff @(posedge clk) begin
        if (!rst_n)    ptr <= '0;
        else if (load) ptr <= load_val;
        else if (inc)  ptr <= ptr + 1'b1;
    end
endmodule

// File: rtl/eeprom_store.sv
// Byte array held in registers. One address serves the synchronous
// write and the combinational read. Contents are not reset.
module eeprom_store #(
    parameter int ADDR_W = 9
) (
    input  logic              clk,
    input  logic              we,
    input  logic [ADDR_W-1:0] addr,
    input  logic [7:0]        wdata,
    output logic [7:0]        rdata
);
    localparam int DEPTH = 1 << ADDR_W;

    logic [7:0] mem [DEPTH];

    // Write port: one byte per strobe.
    always_ff @(posedge clk) begin
        if (we) mem[addr] <= wdata;
    end

    // Read port: byte at the current address.
    always_comb rdata = mem[addr];
endmodule

// File: rtl/eeprom_rd_slave.sv
// Two-wire serial EEPROM slave with current, random and sequential reads.
// Assumes 9 <= ADDR_W <= 10: the address bits above 7 come from the low
// bits of the address byte (just above R/W); the remaining header bits
// between those and the device code are compared with strap_i.
module eeprom_rd_slave
    import eeprom_pkg::*;
#(
    parameter int         ADDR_W   = 9,
    parameter logic [3:0] DEV_CODE = 4'b1010,
    localparam int        PAGE_W   = ADDR_W - 8,
    localparam int        STRAP_W  = 3 - PAGE_W
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               scl_i,
    input  logic               sda_i,
    input  logic [STRAP_W-1:0] strap_i,
    output logic               sda_drive_low_o
);
    logic              sda_s, scl_rise, scl_fall, start_det, stop_det;
    state_t            state;
    kind_t             kind;
    logic [7:0]        rx_sh, tx_sh;
    logic [3:0]        bitcnt;
    logic              rd_dir, rack_ok;
    logic [PAGE_W-1:0] page_q;
    logic [ADDR_W-1:0] ptr, load_val;
    logic [7:0]        rd_data;
    logic              hdr_match, byte_done, ack_exit, tx_load;
    logic              ctr_load, ctr_inc, mem_we;

    eeprom_line_sync u_sync (
        .clk       (clk),
        .rst_n     (rst_n),
        .scl_i     (scl_i),
        .sda_i     (sda_i),
        .sda_s     (sda_s),
        .scl_rise  (scl_rise),
        .scl_fall  (scl_fall),
        .start_det (start_det),
        .stop_det  (stop_det)
    );

    eeprom_addr_ctr #(.ADDR_W(ADDR_W)) u_ctr (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (ctr_load),
        .load_val (load_val),
        .inc      (ctr_inc),
        .ptr      (ptr)
    );

    eeprom_store #(.ADDR_W(ADDR_W)) u_store (
        .clk   (clk),
        .we    (mem_we),
        .addr  (ptr),
        .wdata (rx_sh),
        .rdata (rd_data)
    );

    // Event decode that steers the pointer and the array.
    always_comb begin
        hdr_match = (rx_sh[7:4] == DEV_CODE) && (rx_sh[3:PAGE_W+1] == strap_i);
        byte_done = (state == S_RX) && scl_fall && (bitcnt == 4'd8);
        ack_exit  = (state == S_ACK) && scl_fall;
        tx_load   = (ack_exit && kind == K_DEV && rd_dir)
                  || (state == S_RACK && scl_fall && rack_ok);
        ctr_load  = byte_done && (kind == K_WADDR);
        load_val  = {page_q, rx_sh};
        mem_we    = byte_done && (kind == K_WDATA);
        ctr_inc   = mem_we || tx_load;
    end

    // Bus controller: byte framing, ACK handling and read streaming.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state   <= S_IDLE;
            kind    <= K_DEV;
            bitcnt  <= '0;
            rx_sh   <= '0;
            tx_sh   <= 8'hFF;
            rd_dir  <= 1'b0;
            rack_ok <= 1'b0;
            page_q  <= '0;
        end else if (start_det) begin
            state  <= S_RX;
            kind   <= K_DEV;
            bitcnt <= '0;
        end else if (stop_det) begin
            state <= S_IDLE;
        end else begin
            case (state)
                S_RX: begin
                    if (scl_rise && bitcnt < 4'd8) begin
                        rx_sh  <= {rx_sh[6:0], sda_s};
                        bitcnt <= bitcnt + 1'b1;
                    end else if (byte_done) begin
                        if (kind != K_DEV) begin
                            state <= S_ACK;
                        end else if (hdr_match) begin
                            state  <= S_ACK;
                            rd_dir <= rx_sh[0];
                            page_q <= rx_sh[PAGE_W:1];
                        end else begin
                            state <= S_IDLE;
                        end
                    end
                end
                S_ACK: begin
                    if (ack_exit) begin
                        bitcnt <= '0;
                        if (kind == K_DEV && rd_dir) begin
                            state <= S_TX;
                            tx_sh <= rd_data;
                        end else begin
                            state <= S_RX;
                            if (kind == K_DEV) kind <= K_WADDR;
                            else               kind <= K_WDATA;
                        end
                    end
                end
                S_TX: begin
                    if (scl_fall) begin
                        if (bitcnt == 4'd7) begin
                            state  <= S_RACK;
                            bitcnt <= '0;
                        end else begin
                            tx_sh  <= {tx_sh[6:0], 1'b1};
                            bitcnt <= bitcnt + 1'b1;
                        end
                    end
                end
                S_RACK: begin
                    if (scl_rise) rack_ok <= ~sda_s;
                    if (scl_fall) begin
                        if (rack_ok) begin
                            state  <= S_TX;
                            tx_sh  <= rd_data;
                            bitcnt <= '0;
                        end else begin
                            state <= S_IDLE;
                        end
                    end
                end
                default: state <= S_IDLE;
            endcase
        end
    end

    // Open-drain enable: ACK slot, or a zero data bit.
    always_comb sda_drive_low_o = (state == S_ACK) || (state == S_TX && !tx_sh[7]);
endmodule

// File: rtl/eeprom_rd_slave_chk.sv
// Assertion checker for eeprom_rd_slave, attached by bind.
module eeprom_rd_slave_chk
    import eeprom_pkg::*;
#(
    parameter int         ADDR_W   = 9,
    parameter logic [3:0] DEV_CODE = 4'b1010,
    localparam int        PAGE_W   = ADDR_W - 8,
    localparam int        STRAP_W  = 3 - PAGE_W
) (
    input logic               clk,
    input logic               rst_n,
    input logic               drive,
    input logic               scl_fall,
    input logic               start_det,
    input logic               stop_det,
    input state_t             state,
    input kind_t              kind,
    input logic [7:0]         rx_sh,
    input logic [STRAP_W-1:0] strap_i,
    input logic [3:0]         bitcnt,
    input logic               tx_load,
    input logic               mem_we,
    input logic [ADDR_W-1:0]  ptr
);
    // R1: released whenever idle
    a_r1_idle_released: assert property (@(posedge clk) disable iff (!rst_n)
        (state == S_IDLE) |-> !drive);

    // R2: an address ACK is entered only for a matching header
    a_r2_ack_on_match: assert property (@(posedge clk) disable iff (!rst_n)
        ($rose(state == S_ACK) && kind == K_DEV)
            |-> (rx_sh[7:4] == DEV_CODE && rx_sh[3:PAGE_W+1] == strap_i));

    // R4: a stored byte advances the pointer
    a_r4_write_advances: assert property (@(posedge clk) disable iff (!rst_n)
        mem_we |=> (ptr == $past(ptr) + 1'b1));

    // R7: enable changes only right after SCL fell or a bus condition
    a_r7_change_scl_low: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(drive) |-> ($past(scl_fall) || $past(start_det) || $past(stop_det)));

    // R8: each byte handed to the shifter advances the pointer
    a_r8_read_advances: assert property (@(posedge clk) disable iff (!rst_n)
        tx_load |=> (ptr == $past(ptr) + 1'b1));

    // R9: STOP returns to idle
    a_r9_stop_idle: assert property (@(posedge clk) disable iff (!rst_n)
        (stop_det && !start_det) |=> (state == S_IDLE));

    // R10: START restarts address decoding
    a_r10_start_decode: assert property (@(posedge clk) disable iff (!rst_n)
        start_det |=> (state == S_RX && kind == K_DEV && bitcnt == 4'd0));
endmodule

bind eeprom_rd_slave eeprom_rd_slave_chk #(.ADDR_W(ADDR_W), .DEV_CODE(DEV_CODE)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .drive     (sda_drive_low_o),
    .scl_fall  (scl_fall),
    .start_det (start_det),
    .stop_det  (stop_det),
    .state     (state),
    .kind      (kind),
    .rx_sh     (rx_sh),
    .strap_i   (strap_i),
    .bitcnt    (bitcnt),
    .tx_load   (tx_load),
    .mem_we    (mem_we),
    .ptr       (ptr)
);

// File: tb/eeprom_rd_slave_test.sv
// Bus-master bench with a byte-array model of the expected contents.
module eeprom_rd_slave_test;
    localparam int CLK_P = 10;
    localparam int HALF  = 8;
    localparam int LIMIT = 180000;
    localparam logic [1:0] STRAP = 2'b01;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       scl_m = 1'b1;
    logic       sda_m = 1'b1;
    logic       drv;
    logic       sda_bus;
    logic [1:0] strap = STRAP;

    int errors = 0;
    int checks = 0;
    int cyc = 0;
    int r7_viol = 0;
    logic prev_drv = 1'b0;
    logic prev_scl = 1'b1;

    logic [7:0] ref_mem [512];
    logic [8:0] ref_ptr = '0;

    assign sda_bus = sda_m & ~drv;

    always #(CLK_P/2) clk = ~clk;

    eeprom_rd_slave uut (
        .clk             (clk),
        .rst_n           (rst_n),
        .scl_i           (scl_m),
        .sda_i           (sda_bus),
        .strap_i         (strap),
        .sda_drive_low_o (drv)
    );

    // R7 monitor: the enable must not change across an SCL-high interval.
    always @(negedge clk) begin
        if (rst_n && drv != prev_drv && scl_m && prev_scl) r7_viol++;
        prev_drv = drv;
        prev_scl = scl_m;
    end

    // Watchdog: a hung run is a failed check.
    always @(posedge clk) begin
        cyc++;
        if (cyc > LIMIT) begin
            errors++;
            checks++;
            $display("FAIL watchdog all-R: cycles=%0d expected below %0d", cyc, LIMIT);
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    function automatic logic [7:0] dev_byte(input logic [1:0] st, input logic pg, input logic rw);
        return {4'b1010, st, pg, rw};
    endfunction

    task automatic check(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic tick(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic bus_start;
        sda_m = 1'b1; tick(HALF);
        scl_m = 1'b1; tick(HALF);
        sda_m = 1'b0; tick(HALF);
        scl_m = 1'b0; tick(2);
    endtask

    task automatic bus_stop;
        sda_m = 1'b0; tick(HALF);
        scl_m = 1'b1; tick(HALF);
        sda_m = 1'b1; tick(HALF);
    endtask

    task automatic put_byte(input logic [7:0] b, output bit acked);
        for (int i = 7; i >= 0; i--) begin
            sda_m = b[i]; tick(HALF);
            scl_m = 1'b1; tick(HALF);
            scl_m = 1'b0; tick(2);
        end
        sda_m = 1'b1; tick(HALF);
        scl_m = 1'b1; tick(HALF/2);
        acked = !sda_bus;
        tick(HALF/2);
        scl_m = 1'b0; tick(2);
    endtask

    task automatic get_byte(input bit give_ack, output logic [7:0] b);
        sda_m = 1'b1;
        for (int i = 7; i >= 0; i--) begin
            tick(HALF);
            scl_m = 1'b1; tick(HALF/2);
            b[i] = sda_bus;
            tick(HALF/2);
            scl_m = 1'b0; tick(2);
        end
        sda_m = !give_ack; tick(HALF);
        scl_m = 1'b1; tick(HALF);
        scl_m = 1'b0; tick(2);
        sda_m = 1'b1;
    endtask

    // Header, word address, then n data bytes; the model follows.
    task automatic do_write(input logic [8:0] addr, input int n);
        bit ak;
        logic [7:0] d;
        bus_start;
        put_byte(dev_byte(STRAP, addr[8], 1'b0), ak);
        check(ak, "R2 write header ack", ak, 1);
        put_byte(addr[7:0], ak);
        check(ak, "R3 word address ack", ak, 1);
        ref_ptr = addr;
        for (int k = 0; k < n; k++) begin
            d = 8'($urandom);
            put_byte(d, ak);
            check(ak, "R4 data byte ack", ak, 1);
            ref_mem[ref_ptr] = d;
            ref_ptr = ref_ptr + 1'b1;
        end
        bus_stop;
    endtask

    // Read of n bytes, either random (with dummy write) or current-address.
    task automatic do_read(input bit rnd, input logic [8:0] addr, input int n, input string req);
        bit ak;
        logic [7:0] d;
        bus_start;
        if (rnd) begin
            put_byte(dev_byte(STRAP, addr[8], 1'b0), ak);
            check(ak, "R6 dummy header ack", ak, 1);
            put_byte(addr[7:0], ak);
            check(ak, "R6 dummy address ack", ak, 1);
            ref_ptr = addr;
            bus_start;
        end
        put_byte(dev_byte(STRAP, 1'b0, 1'b1), ak);
        check(ak, "R2 read header ack", ak, 1);
        for (int k = 0; k < n; k++) begin
            get_byte(k != n - 1, d);
            check(d == ref_mem[ref_ptr], req, d, ref_mem[ref_ptr]);
            ref_ptr = ref_ptr + 1'b1;
        end
        tick(4);
        check(drv == 1'b0, "R9 released after NACK", drv, 0);
        bus_stop;
    endtask

    initial begin
        bit ak;
        logic [7:0] d;
        void'($urandom(32'h5EED_2C02));
        tick(4);
        check(drv == 1'b0, "R1 drive in reset", drv, 0);
        rst_n = 1'b1;
        tick(20);
        check(drv == 1'b0, "R1 released after reset", drv, 0);

        // Preload across the wrap, then read it back across the wrap.
        do_write(9'h1FC, 8);
        check(ref_ptr == 9'h004, "R4 model wrap", ref_ptr, 4);
        do_read(1'b1, 9'h1FE, 4, "R8 sequential wrap data");
        do_read(1'b0, 9'h000, 2, "R5 current read after wrap");

        // Upper half via the page bit.
        do_write(9'h1A0, 3);
        do_write(9'h0A0, 3);
        do_read(1'b1, 9'h1A0, 3, "R3 page bit selects upper half");
        do_read(1'b0, 9'h000, 1, "R5 current read after sequence");

        // Wrong strap: no ACK, later bytes ignored, no write happens.
        bus_start;
        put_byte(dev_byte(~STRAP, 1'b0, 1'b0), ak);
        check(!ak, "R2 strap mismatch no ack", ak, 0);
        put_byte(8'hA1, ak);
        check(!ak, "R2 ignored byte no ack", ak, 0);
        put_byte(8'h5A, ak);
        check(!ak, "R2 ignored data no ack", ak, 0);
        bus_stop;
        do_read(1'b1, 9'h0A1, 1, "R2 ignored bytes not stored");

        // Wrong device code on a read: no ACK, pointer untouched.
        bus_start;
        put_byte(8'h92 | {4'h0, STRAP, 2'b01}, ak);
        check(!ak, "R2 device code mismatch", ak, 0);
        bus_stop;
        do_read(1'b0, 9'h000, 1, "R2 pointer unchanged by refused read");

        // Write header then repeated START into a read: pointer unchanged.
        bus_start;
        put_byte(dev_byte(STRAP, 1'b1, 1'b0), ak);
        check(ak, "R10 header before restart", ak, 1);
        bus_start;
        put_byte(dev_byte(STRAP, 1'b0, 1'b1), ak);
        check(ak, "R10 read header after restart", ak, 1);
        get_byte(1'b0, d);
        check(d == ref_mem[ref_ptr], "R10 read from unchanged pointer", d, ref_mem[ref_ptr]);
        ref_ptr = ref_ptr + 1'b1;
        bus_stop;

        // Dummy write stores nothing: reread the same address twice.
        do_read(1'b1, 9'h1FD, 1, "R6 random read");
        do_read(1'b1, 9'h1FD, 2, "R6 dummy write left data intact");

        // Constrained random mix.
        for (int it = 0; it < 14; it++) begin
            logic [8:0] a;
            a = 9'($urandom);
            do_write(a, 1 + int'($urandom % 4));
            do_read(1'b1, a, 1 + int'($urandom % 3), "R8 random sequential");
            do_read(1'b0, 9'h000, 1, "R5 random current read");
        end

        check(r7_viol == 0, "R7 enable stable while SCL high", r7_viol, 0);
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule